// File: doc/BRIEF.md
# Paired-Instruction Accumulator Sequencer

This block is the control unit of a small accumulator machine. Each 40-bit memory word carries two 20-bit instructions. The sequencer reads a word once and runs its left instruction. It then runs the right instruction from a holding register, with no second memory access. Programs and data sit in a synchronous word-addressed RAM inside the block. While the sequencer is idle or halted, the surrounding logic fills that RAM through a load port and inspects it through a read-only peek port.

A one-cycle `run` pulse starts execution at word 0. The sequencer then steps through fixed phases. Fetch moves the program counter into the memory address register, reads the word into the memory buffer register, and splits it. Execute moves the operand address into the memory address register, performs the access, and updates the accumulator, or the accumulator and the quotient register. A halt instruction parks the sequencer until the next `run` pulse. The accumulator, quotient register and program counter are visible at the ports at all times.

Top module: `pw_core`

## Requirements
- R1: After reset, `busy` and `halted` are 0, and `pc_out`, `ac_out` and `mq_out` are all zero.
- R2: A word holds the left opcode in bits 7:0 and the left address in bits 19:8. It holds the right opcode in bits 27:20 and the right address in bits 39:28. The left instruction executes before the right one. Opcodes are 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 multiply, 6 jump-to-left-half and 7 jump-to-right-half. Any other code does nothing.
- R3: The right instruction runs from the copy taken at fetch time. A store by the left instruction into its own word does not alter the right instruction that follows.
- R4: The program counter advances by one only after the right half of a word has been consumed. A halt in either half leaves `pc_out` at that word's address.
- R5: Load copies the addressed word into the accumulator. Store writes the accumulator into the addressed word.
- R6: Add and subtract compute AC+M and AC−M modulo 2^40 and leave MQ unchanged.
- R7: Multiply forms the signed 80-bit product of AC and M. The upper 40 bits go to AC and the lower 40 bits go to MQ.
- R8: Jump-to-left-half fetches the target word and runs both of its halves. A pending right instruction of the current word is discarded.
- R9: Jump-to-right-half fetches the target word and runs only its right instruction. The sequencer then continues at the next word.
- R10: Halt raises `halted`, drops `busy`, skips any remaining right half and writes no memory. `halted` holds until a `run` pulse, which restarts execution at word 0.
- R11: Operand and jump addresses select the memory word modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start pulse, taken while idle or halted |
| ld_we | input | 1 | Load-port write enable, used only when not busy |
| ld_addr | input | log2(DEPTH) | Load-port word address |
| ld_data | input | 40 | Load-port write data |
| peek_addr | input | log2(DEPTH) | Peek-port word address |
| peek_data | output | 40 | Word at `peek_addr`, one cycle later |
| busy | output | 1 | Sequencer is executing |
| halted | output | 1 | Sequencer stopped on a halt instruction |
| pc_out | output | 12 | Program counter |
| ac_out | output | 40 | Accumulator |
| mq_out | output | 40 | Quotient register |

## Verification
The bench builds the block with DEPTH set to 32. With that setting, a 12-bit address such as 42 falls outside the physical memory, so the bench can show an operand address wrapping onto word 10. The 40-bit word width is fixed, so the multiply vectors cover the sign and carry boundaries of the full 80-bit product. Those boundaries are a negative result, the most negative operand, and a product that lands entirely in the upper half. The self-modifying store and the two jump flavours show that the right half comes from the holding register and never from a second read.

// File: rtl/pw_pkg.sv
package pw_pkg;

    parameter int OPC_W   = 8;
    parameter int ADDR_W  = 12;
    parameter int INSTR_W = OPC_W + ADDR_W;
    parameter int WORD_W  = 2 * INSTR_W;

    typedef logic [WORD_W-1:0] word_t;

    // opcode in the low bits, address above it
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [OPC_W-1:0]  op;
    } instr_t;

    // left instruction occupies the low half of the word
    typedef struct packed {
        instr_t right;
        instr_t left;
    } pair_t;

    localparam logic [OPC_W-1:0] OP_HALT  = 8'd0;
    localparam logic [OPC_W-1:0] OP_LOAD  = 8'd1;
    localparam logic [OPC_W-1:0] OP_STORE = 8'd2;
    localparam logic [OPC_W-1:0] OP_ADD   = 8'd3;
    localparam logic [OPC_W-1:0] OP_SUB   = 8'd4;
    localparam logic [OPC_W-1:0] OP_MUL   = 8'd5;
    localparam logic [OPC_W-1:0] OP_JMPL  = 8'd6;
    localparam logic [OPC_W-1:0] OP_JMPR  = 8'd7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_FREAD,
        S_FLATCH,
        S_SPLIT,
        S_DECODE,
        S_MEM,
        S_MLATCH,
        S_ALU,
        S_XFER,
        S_HALT
    } seq_state_e;

    function automatic instr_t left_of(word_t w);
        pair_t p;
        p = pair_t'(w);
        return p.left;
    endfunction

    function automatic instr_t right_of(word_t w);
        pair_t p;
        p = pair_t'(w);
        return p.right;
    endfunction

    function automatic logic reads_operand(logic [OPC_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
    endfunction

endpackage

// File: rtl/pw_ram.sv
module pw_ram
    import pw_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  word_t         wdata_i,
    output word_t         rdata_o,
    input  logic [AW-1:0] peek_addr_i,
    output word_t         peek_data_o
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
        rdata_o     <= mem[addr_i];
        peek_data_o <= mem[peek_addr_i];
    end

endmodule

// File: rtl/pw_alu.sv
module pw_alu
    import pw_pkg::*;
(
    input  logic [OPC_W-1:0] op_i,
    input  word_t            ac_i,
    input  word_t            mq_i,
    input  word_t            mbr_i,
    output word_t            ac_o,
    output word_t            mq_o
);

    localparam int PROD_W = 2 * WORD_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        // sign-extend both factors; the low PROD_W bits are the signed product
        prod = {{WORD_W{ac_i[WORD_W-1]}}, ac_i} * {{WORD_W{mbr_i[WORD_W-1]}}, mbr_i};
        ac_o = ac_i;
        mq_o = mq_i;
        case (op_i)
            OP_LOAD: ac_o = mbr_i;
            OP_ADD:  ac_o = ac_i + mbr_i;
            OP_SUB:  ac_o = ac_i - mbr_i;
            OP_MUL: begin
                ac_o = prod[PROD_W-1:WORD_W];
                mq_o = prod[WORD_W-1:0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
    import pw_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  word_t             mem_rdata_i,
    input  word_t             alu_ac_i,
    input  word_t             alu_mq_i,
    output logic [AW-1:0]     mem_addr_o,
    output logic              mem_we_o,
    output word_t             mem_wdata_o,
    output logic [OPC_W-1:0]  ir_op_o,
    output word_t             ac_o,
    output word_t             mq_o,
    output word_t             mbr_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] mar_o,
    output seq_state_e        state_o,
    output logic              ibr_valid_o,
    output logic              take_right_o
);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    word_t             mbr_q;
    word_t             ac_q;
    word_t             mq_q;
    instr_t            ir_q;
    instr_t            ibr_q;
    logic              ibr_valid_q;
    logic              take_right_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            pc_q         <= '0;
            mar_q        <= '0;
            mbr_q        <= '0;
            ac_q         <= '0;
            mq_q         <= '0;
            ir_q         <= '0;
            ibr_q        <= '0;
            ibr_valid_q  <= 1'b0;
            take_right_q <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE, S_HALT: begin
                    if (run_i) begin
                        pc_q         <= '0;
                        ibr_valid_q  <= 1'b0;
                        take_right_q <= 1'b0;
                        state_q      <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    mar_q   <= pc_q;
                    state_q <= S_FREAD;
                end
                S_FREAD: state_q <= S_FLATCH;
                S_FLATCH: begin
                    mbr_q   <= mem_rdata_i;
                    state_q <= S_SPLIT;
                end
                S_SPLIT: begin
                    if (take_right_q) begin
                        ir_q         <= right_of(mbr_q);
                        ibr_valid_q  <= 1'b0;
                        take_right_q <= 1'b0;
                    end else begin
                        ir_q        <= left_of(mbr_q);
                        ibr_q       <= right_of(mbr_q);
                        ibr_valid_q <= 1'b1;
                    end
                    state_q <= S_DECODE;
                end
                S_DECODE: begin
                    mar_q   <= ir_q.addr;
                    state_q <= S_MEM;
                end
                S_MEM: begin
                    if (reads_operand(ir_q.op)) begin
                        state_q <= S_MLATCH;
                    end else if (ir_q.op == OP_JMPL || ir_q.op == OP_JMPR) begin
                        pc_q         <= mar_q;
                        ibr_valid_q  <= 1'b0;
                        take_right_q <= (ir_q.op == OP_JMPR);
                        state_q      <= S_FETCH;
                    end else if (ir_q.op == OP_HALT) begin
                        state_q <= S_HALT;
                    end else if (ibr_valid_q) begin
                        state_q <= S_XFER;
                    end else begin
                        pc_q    <= pc_q + ADDR_W'(1);
                        state_q <= S_FETCH;
                    end
                end
                S_MLATCH: begin
                    mbr_q   <= mem_rdata_i;
                    state_q <= S_ALU;
                end
                S_ALU: begin
                    ac_q <= alu_ac_i;
                    mq_q <= alu_mq_i;
                    if (ibr_valid_q) begin
                        state_q <= S_XFER;
                    end else begin
                        pc_q    <= pc_q + ADDR_W'(1);
                        state_q <= S_FETCH;
                    end
                end
                S_XFER: begin
                    ir_q        <= ibr_q;
                    ibr_valid_q <= 1'b0;
                    state_q     <= S_DECODE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign mem_addr_o   = mar_q[AW-1:0];
    assign mem_we_o     = (state_q == S_MEM) && (ir_q.op == OP_STORE);
    assign mem_wdata_o  = ac_q;
    assign ir_op_o      = ir_q.op;
    assign ac_o         = ac_q;
    assign mq_o         = mq_q;
    assign mbr_o        = mbr_q;
    assign pc_o         = pc_q;
    assign mar_o        = mar_q;
    assign state_o      = state_q;
    assign ibr_valid_o  = ibr_valid_q;
    assign take_right_o = take_right_q;

endmodule

// File: rtl/pw_core.sv
module pw_core
    import pw_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    input  logic                     ld_we,
    input  logic [$clog2(DEPTH)-1:0] ld_addr,
    input  logic [WORD_W-1:0]        ld_data,
    input  logic [$clog2(DEPTH)-1:0] peek_addr,
    output logic [WORD_W-1:0]        peek_data,
    output logic                     busy,
    output logic                     halted,
    output logic [ADDR_W-1:0]        pc_out,
    output logic [WORD_W-1:0]        ac_out,
    output logic [WORD_W-1:0]        mq_out
);

    localparam int AW = $clog2(DEPTH);

    seq_state_e        st;
    logic [AW-1:0]     core_addr;
    logic              core_we;
    word_t             core_wdata;
    word_t             ram_rdata;
    logic              ram_we;
    logic [AW-1:0]     ram_addr;
    word_t             ram_wdata;
    logic [OPC_W-1:0]  ir_op;
    word_t             ac_w;
    word_t             mq_w;
    word_t             mbr_w;
    word_t             alu_ac;
    word_t             alu_mq;
    logic [ADDR_W-1:0] pc_w;
    logic [ADDR_W-1:0] mar_w;
    logic              ibv_w;
    logic              tr_w;

    assign halted = (st == S_HALT);
    assign busy   = !((st == S_IDLE) || (st == S_HALT));

    // the load port owns the memory only while the sequencer is stopped
    assign ram_we    = busy ? core_we    : ld_we;
    assign ram_addr  = busy ? core_addr  : ld_addr;
    assign ram_wdata = busy ? core_wdata : ld_data;

    pw_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk         (clk),
        .we_i        (ram_we),
        .addr_i      (ram_addr),
        .wdata_i     (ram_wdata),
        .rdata_o     (ram_rdata),
        .peek_addr_i (peek_addr),
        .peek_data_o (peek_data)
    );

    pw_alu u_alu (
        .op_i  (ir_op),
        .ac_i  (ac_w),
        .mq_i  (mq_w),
        .mbr_i (mbr_w),
        .ac_o  (alu_ac),
        .mq_o  (alu_mq)
    );

    pw_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .run_i        (run),
        .mem_rdata_i  (ram_rdata),
        .alu_ac_i     (alu_ac),
        .alu_mq_i     (alu_mq),
        .mem_addr_o   (core_addr),
        .mem_we_o     (core_we),
        .mem_wdata_o  (core_wdata),
        .ir_op_o      (ir_op),
        .ac_o         (ac_w),
        .mq_o         (mq_w),
        .mbr_o        (mbr_w),
        .pc_o         (pc_w),
        .mar_o        (mar_w),
        .state_o      (st),
        .ibr_valid_o  (ibv_w),
        .take_right_o (tr_w)
    );

    assign pc_out = pc_w;
    assign ac_out = ac_w;
    assign mq_out = mq_w;

endmodule

// File: rtl/pw_core_chk.sv
module pw_core_chk
    import pw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              halted,
    input seq_state_e        state,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] mar,
    input word_t             mbr,
    input logic              ibr_valid,
    input logic              take_right,
    input logic              mem_we
);

    // R2: the word read is addressed by the program counter
    assert_fetch_from_pc_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_FREAD) |-> (mar == pc));

    // R2: a normal split leaves the right half pending
    assert_split_holds_right_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_SPLIT && !take_right) |=> ibr_valid);

    // R3: moving the right half into IR involves no memory data
    assert_xfer_no_read_R3: assert property (@(posedge clk) disable iff (rst)
        (state == S_XFER) |=> $stable(mbr));

    // R4: the PC moves only once no right half is pending, on a jump, or on restart
    assert_pc_after_right_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc) |-> (!$past(ibr_valid) ||
                          $past(state) == S_MEM ||
                          $past(state) == S_IDLE ||
                          $past(state) == S_HALT));

    // R9: a right-half jump target leaves nothing pending
    assert_jright_only_R9: assert property (@(posedge clk) disable iff (rst)
        (state == S_SPLIT && take_right) |=> !ibr_valid);

    // R10: a halted sequencer writes no memory
    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    // R10: halted persists until a start pulse
    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (halted && !run) |=> halted);

endmodule

bind pw_core pw_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .halted     (halted),
    .state      (st),
    .pc         (pc_w),
    .mar        (mar_w),
    .mbr        (mbr_w),
    .ibr_valid  (ibv_w),
    .take_right (tr_w),
    .mem_we     (core_we)
);

// File: tb/sim_pw_core.sv
module sim_pw_core;
    import pw_pkg::*;

    localparam int DEPTH = 32;
    localparam int AW    = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run = 1'b0;
    logic              ld_we = 1'b0;
    logic [AW-1:0]     ld_addr = '0;
    logic [WORD_W-1:0] ld_data = '0;
    logic [AW-1:0]     peek_addr = '0;
    logic [WORD_W-1:0] peek_data;
    logic              busy;
    logic              halted;
    logic [ADDR_W-1:0] pc_out;
    logic [WORD_W-1:0] ac_out;
    logic [WORD_W-1:0] mq_out;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4ns clk = ~clk;

    pw_core #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .run(run),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .busy(busy), .halted(halted),
        .pc_out(pc_out), .ac_out(ac_out), .mq_out(mq_out)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [39:0] a;
        logic [39:0] b;
        logic [39:0] eac;
        logic [39:0] emq;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd3, 40'd7,              40'd5,   40'd12,             40'd0},
        '{8'd3, 40'hFF_FFFF_FFFF,   40'd1,   40'd0,              40'd0},
        '{8'd4, 40'd5,              40'd7,   40'hFF_FFFF_FFFE,   40'd0},
        '{8'd4, 40'd0,              40'h80_0000_0000, 40'h80_0000_0000, 40'd0},
        '{8'd5, 40'd3,              40'd5,   40'd0,              40'd15},
        '{8'd5, 40'hFF_FFFF_FFFE,   40'd3,   40'hFF_FFFF_FFFF,   40'hFF_FFFF_FFFA},
        '{8'd5, 40'h80_0000_0000,   40'd2,   40'hFF_FFFF_FFFF,   40'd0},
        '{8'd5, 40'h10_0000_0000,   40'd256, 40'd16,             40'd0}
    };

    function automatic logic [39:0] mk(logic [7:0] opl, logic [11:0] adl,
                                       logic [7:0] opr, logic [11:0] adr);
        return {adr, opr, adl, opl};
    endfunction

    task automatic chk(string req, logic [79:0] got, logic [79:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(int a, logic [39:0] d);
        @(negedge clk);
        ld_we   = 1'b1;
        ld_addr = AW'(a);
        ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic peek(int a, output logic [39:0] d);
        @(negedge clk);
        peek_addr = AW'(a);
        @(negedge clk);
        d = peek_data;
    endtask

    task automatic go(string req);
        int n;
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " halt reached"}, {79'd0, halted}, 80'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [39:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy",   {79'd0, busy},   80'd0);
        chk("R1 halted", {79'd0, halted}, 80'd0);
        chk("R1 pc",     {68'd0, pc_out}, 80'd0);
        chk("R1 ac",     {40'd0, ac_out}, 80'd0);
        chk("R1 mq",     {40'd0, mq_out}, 80'd0);

        // R2 R6 R7: load left, arithmetic right, table walk
        for (int i = 0; i < 8; i++) begin
            wr(10, VECS[i].a);
            wr(11, VECS[i].b);
            wr(0, mk(OP_LOAD, 12'd10, VECS[i].op, 12'd11));
            wr(1, mk(OP_HALT, 12'd0, OP_HALT, 12'd0));
            go("R2");
            if (VECS[i].op == OP_MUL) begin
                chk("R7 ac high", {40'd0, ac_out}, {40'd0, VECS[i].eac});
                chk("R7 mq low",  {40'd0, mq_out}, {40'd0, VECS[i].emq});
            end else begin
                chk("R6 ac", {40'd0, ac_out}, {40'd0, VECS[i].eac});
            end
            chk("R4 pc after word", {68'd0, pc_out}, 80'd1);
        end

        // R6: add/sub keep MQ (last vector left MQ at 0, set it nonzero first)
        wr(10, 40'd3);
        wr(11, 40'd7);
        wr(0, mk(OP_LOAD, 12'd10, OP_MUL, 12'd11));
        wr(1, mk(OP_ADD, 12'd11, OP_HALT, 12'd0));
        go("R6");
        chk("R6 mq kept", {40'd0, mq_out}, 80'd21);
        chk("R6 ac sum",  {40'd0, ac_out}, 80'd7);

        // R4 R10: halt in right half keeps pc at the word
        wr(10, 40'd77);
        wr(0, mk(OP_LOAD, 12'd10, OP_HALT, 12'd0));
        go("R4");
        chk("R4 pc on right halt", {68'd0, pc_out}, 80'd0);
        chk("R5 load", {40'd0, ac_out}, 80'd77);
        chk("R10 busy low", {79'd0, busy}, 80'd0);

        // R3 R5: left store overwrites its own word, right half still from buffer
        wr(20, 40'd99);
        wr(21, 40'd123);
        wr(0, mk(OP_LOAD, 12'd21, OP_JMPL, 12'd2));
        wr(2, mk(OP_STORE, 12'd2, OP_LOAD, 12'd20));
        wr(3, mk(OP_HALT, 12'd0, OP_HALT, 12'd0));
        go("R3");
        chk("R3 buffered right", {40'd0, ac_out}, 80'd99);
        peek(2, d);
        chk("R5 store", {40'd0, d}, 80'd123);
        chk("R4 pc after stored word", {68'd0, pc_out}, 80'd3);

        // R8: left jump discards pending right
        wr(10, 40'd4);
        wr(11, 40'd6);
        wr(12, 40'd1000);
        wr(0, mk(OP_JMPL, 12'd3, OP_LOAD, 12'd12));
        wr(3, mk(OP_LOAD, 12'd10, OP_ADD, 12'd11));
        wr(4, mk(OP_HALT, 12'd0, OP_HALT, 12'd0));
        go("R8");
        chk("R8 ac", {40'd0, ac_out}, 80'd10);
        chk("R8 pc", {68'd0, pc_out}, 80'd4);

        // R9: right jump runs only the target's right half
        wr(0, mk(OP_LOAD, 12'd10, OP_JMPR, 12'd5));
        wr(5, mk(OP_ADD, 12'd12, OP_ADD, 12'd11));
        wr(6, mk(OP_HALT, 12'd0, OP_HALT, 12'd0));
        go("R9");
        chk("R9 ac", {40'd0, ac_out}, 80'd10);
        chk("R9 pc", {68'd0, pc_out}, 80'd6);

        // R10: halt on the left skips the right store; restart from word 0
        wr(30, 40'd55);
        wr(0, mk(OP_HALT, 12'd0, OP_STORE, 12'd30));
        go("R10");
        peek(30, d);
        chk("R10 memory untouched", {40'd0, d}, 80'd55);
        chk("R10 pc stays", {68'd0, pc_out}, 80'd0);
        chk("R10 ac held", {40'd0, ac_out}, 80'd10);

        // R11: address 42 wraps onto word 10 with DEPTH 32
        wr(10, 40'd4321);
        wr(0, mk(OP_LOAD, 12'd42, OP_HALT, 12'd0));
        go("R11");
        chk("R11 alias", {40'd0, ac_out}, 80'd4321);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule